// File: doc/BRIEF.md
# Single-Wire RGB LED Bit Encoder

This block turns 24-bit colour words into the pulse train that drives a chain of single-wire addressable RGB LEDs. Every bit goes out as three timed phases on one pin: a fixed high phase, then a phase whose level is the bit value, then a fixed low phase. A host hands over one word per LED through a valid/ready handshake and marks the final LED of a frame with a flag. The encoder then shifts the bits out. Once the final bit has gone, it holds the line low for a latch gap so that the chain takes over the new colours.

All phase lengths are parameters in system-clock cycles. At elaboration the top level compares each length against the nominal phase times and their tolerance band, using the clock period parameter. A word that arrives late never stalls a bit halfway through. The line only rests low after a completed phase three, because the LEDs accept a long low time but need accurate high times.

Top module: `ledPulseEncoder`

## Requirements
- R1: A synchronous active-high `rst` drives `ledOut` low, `busy` low and `inReady` high one edge later, and discards any word that was partly sent. After reset the line stays low until a new word is accepted.
- R2: A word is taken on a rising edge where `inValid` and `inReady` are both high, and `ledOut` is high in the cycle that follows that edge.
- R3: A '1' bit is high for PH1_CYC+PH2_CYC cycles (40 by default) and a '0' bit is high for PH1_CYC cycles (20). The low time after a bit is at least PH3_CYC cycles (23) for a '1' and PH2_CYC+PH3_CYC cycles (43) for a '0'.
- R4: Bits are sent from `inData[23]` down to `inData[0]`. Bits [23:16] hold green, bits [15:8] hold red and bits [7:0] hold blue, so each colour byte goes out MSB first.
- R5: When the next word of a frame is already valid, it is accepted in the final cycle of the previous word's last low phase, so the low time between the two words is exactly the R3 minimum.
- R6: If no word is offered after a word that is not flagged last, `ledOut` stays low, `busy` stays high and `inReady` stays high until a word arrives. The late word is still encoded correctly.
- R7: After the word flagged by `inLast`, the line stays low for the final bit's low phase plus LATCH_CYC cycles. During that time `busy` is high and `inReady` is low. `busy` falls immediately afterwards.
- R8: While `busy` is low, `ledOut` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Host offers a colour word |
| inReady | output | 1 | Encoder takes the offered word on this edge |
| inData | input | 24 | Colour word: green [23:16], red [15:8], blue [7:0] |
| inLast | input | 1 | Offered word is the last LED of the frame |
| ledOut | output | 1 | Serial line to the LED chain |
| busy | output | 1 | High from the first accepted word until the latch gap ends |

## Verification
The bench measures every high and low run on the line and decodes the high widths back into bits and words. It feeds three kinds of words:
- Single-colour words (one byte full, the others empty), which show whether the byte order is correct.
- Alternating and asymmetric patterns such as A55AC3, 800001 and 7FFFFE, which expose bit reversal and lost first or last bits.
- All-zeros and all-ones words, which check both pulse widths on long runs.

Some words in a frame are offered back to back and one is offered late. These two cases separate the exact minimum gap between words from a stretched idle low. The frame tail is counted cycle by cycle for a last bit of '1' and for a last bit of '0'. A reset in the middle of a word checks that its remaining bits never appear on the line.

// File: rtl/ledEncPkg.sv
package ledEncPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PH1,
    ST_PH2,
    ST_PH3,
    ST_LATCH
  } encState_t;

  // strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic load;     // capture host word
    logic shift;    // advance to next bit
    logic drvHigh;  // next cycle is the fixed high phase
    logic drvData;  // next cycle is the data phase
  } encStrobe_t;

endpackage

// File: rtl/ledEncDatapath.sv
module ledEncDatapath
  import ledEncPkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  encStrobe_t        strobe,
  input  logic [WORD_W-1:0] inData,
  input  logic              inLast,
  output logic              ledOut,
  output logic              bitLast,
  output logic              lastWord
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              lastFlag;
  logic              ledQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      lastFlag <= 1'b0;
      ledQ     <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg <= inData;
        bitCnt   <= '0;
        lastFlag <= inLast;
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        bitCnt   <= bitCnt + 1'b1;
      end
      // line level for the next cycle: high phase, or data phase with current MSB
      ledQ <= strobe.drvHigh | (strobe.drvData & shiftReg[WORD_W-1]);
    end
  end

  assign ledOut   = ledQ;
  assign bitLast  = (bitCnt == LAST_IDX);
  assign lastWord = lastFlag;

endmodule

// File: rtl/ledEncCtrl.sv
module ledEncCtrl
  import ledEncPkg::*;
#(
  parameter int PH1_CYC   = 20,
  parameter int PH2_CYC   = 20,
  parameter int PH3_CYC   = 23,
  parameter int LATCH_CYC = 2500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       bitLast,
  input  logic       lastWord,
  output logic       inReady,
  output logic       busy,
  output encStrobe_t strobe,
  output encState_t  state
);

  localparam int MAX_A = (PH1_CYC > PH2_CYC) ? PH1_CYC : PH2_CYC;
  localparam int MAX_B = (PH3_CYC > LATCH_CYC) ? PH3_CYC : LATCH_CYC;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_D + 1);

  encState_t        nxt;
  logic [TMR_W-1:0] tmr;
  logic             tDone;

  assign tDone = (tmr == '0);

  function automatic logic [TMR_W-1:0] durOf(input encState_t s);
    case (s)
      ST_PH1:   durOf = TMR_W'(PH1_CYC - 1);
      ST_PH2:   durOf = TMR_W'(PH2_CYC - 1);
      ST_PH3:   durOf = TMR_W'(PH3_CYC - 1);
      ST_LATCH: durOf = TMR_W'(LATCH_CYC - 1);
      default:  durOf = '0;
    endcase
  endfunction

  always_comb begin
    nxt          = state;
    strobe.load  = 1'b0;
    strobe.shift = 1'b0;
    inReady      = 1'b0;
    case (state)
      ST_IDLE, ST_WAIT: begin
        inReady = 1'b1;
        if (inValid) begin
          nxt         = ST_PH1;
          strobe.load = 1'b1;
        end
      end
      ST_PH1: if (tDone) nxt = ST_PH2;
      ST_PH2: if (tDone) nxt = ST_PH3;
      ST_PH3: begin
        if (tDone) begin
          if (!bitLast) begin
            nxt          = ST_PH1;
            strobe.shift = 1'b1;
          end else if (!lastWord) begin
            inReady = 1'b1;
            if (inValid) begin
              nxt         = ST_PH1;
              strobe.load = 1'b1;
            end else begin
              nxt = ST_WAIT;
            end
          end else begin
            nxt = ST_LATCH;
          end
        end
      end
      ST_LATCH: if (tDone) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    strobe.drvHigh = (nxt == ST_PH1);
    strobe.drvData = (nxt == ST_PH2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) tmr <= durOf(nxt);
      else if (!tDone)  tmr <= tmr - 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ledPulseEncoder.sv
module ledPulseEncoder
  import ledEncPkg::*;
#(
  parameter int CLK_PS    = 20000,
  parameter int WORD_W    = 24,
  parameter int PH1_CYC   = 20,
  parameter int PH2_CYC   = 20,
  parameter int PH3_CYC   = 23,
  parameter int LATCH_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inLast,
  output logic              ledOut,
  output logic              busy
);

  // phase lengths in picoseconds, compared with nominal +/- tolerance
  localparam longint PH1_PS   = longint'(PH1_CYC) * CLK_PS;
  localparam longint PH2_PS   = longint'(PH2_CYC) * CLK_PS;
  localparam longint PH3_PS   = longint'(PH3_CYC) * CLK_PS;
  localparam longint LATCH_PS = longint'(LATCH_CYC) * CLK_PS;
  localparam longint TOL_PS   = 150000;

  generate
    if (PH1_PS < 400000 - TOL_PS || PH1_PS > 400000 + TOL_PS) begin : gBadPh1
      $error("high phase length outside tolerance");
    end
    if (PH2_PS < 400000 - TOL_PS || PH2_PS > 400000 + TOL_PS) begin : gBadPh2
      $error("data phase length outside tolerance");
    end
    if (PH3_PS < 450000 - TOL_PS || PH3_PS > 450000 + TOL_PS) begin : gBadPh3
      $error("low phase length outside tolerance");
    end
    if (LATCH_PS < 64'd50000000) begin : gBadLatch
      $error("latch gap shorter than 50 us");
    end
  endgenerate

  encStrobe_t strobe;
  encState_t  ctrlState;
  logic       bitLast;
  logic       lastWord;

  ledEncCtrl #(
    .PH1_CYC  (PH1_CYC),
    .PH2_CYC  (PH2_CYC),
    .PH3_CYC  (PH3_CYC),
    .LATCH_CYC(LATCH_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .bitLast (bitLast),
    .lastWord(lastWord),
    .inReady (inReady),
    .busy    (busy),
    .strobe  (strobe),
    .state   (ctrlState)
  );

  ledEncDatapath #(
    .WORD_W(WORD_W)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .inLast  (inLast),
    .ledOut  (ledOut),
    .bitLast (bitLast),
    .lastWord(lastWord)
  );

endmodule

// File: rtl/ledEncChecker.sv
module ledEncChecker
  import ledEncPkg::*;
#(
  parameter int PH1_CYC = 20,
  parameter int PH2_CYC = 20
) (
  input logic      clk,
  input logic      rst,
  input logic      inValid,
  input logic      inReady,
  input logic      ledOut,
  input logic      busy,
  input encState_t state
);

  logic [15:0] highLen;

  always_ff @(posedge clk) begin
    if (rst)         highLen <= '0;
    else if (ledOut) highLen <= highLen + 1'b1;
    else             highLen <= '0;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!ledOut && !busy && inReady));

  // R2
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> ledOut);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ledOut) && !$past(rst)) |->
      (highLen == 16'(PH1_CYC) || highLen == 16'(PH1_CYC + PH2_CYC)));

  // R7
  latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH) |-> (!ledOut && !inReady && busy));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ledOut && inReady));

endmodule

bind ledPulseEncoder ledEncChecker #(
  .PH1_CYC(PH1_CYC),
  .PH2_CYC(PH2_CYC)
) u_encChk (
  .clk    (clk),
  .rst    (rst),
  .inValid(inValid),
  .inReady(inReady),
  .ledOut (ledOut),
  .busy   (busy),
  .state  (ctrlState)
);

// File: tb/test_ledPulseEncoder.sv
`timescale 1ns/1ps
module test_ledPulseEncoder;

  localparam int H1 = 20;
  localparam int D2 = 20;
  localparam int L3 = 23;
  localparam int LT = 2500;

  typedef struct packed {
    logic [23:0] data;
    logic        last;
    logic [7:0]  delay;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{24'hFF0000, 1'b0, 8'd0},
    '{24'h00FF00, 1'b0, 8'd0},
    '{24'h0000FF, 1'b1, 8'd0},
    '{24'hA55AC3, 1'b0, 8'd0},
    '{24'h000000, 1'b0, 8'd40},
    '{24'hFFFFFF, 1'b1, 8'd0},
    '{24'h800001, 1'b0, 8'd0},
    '{24'h7FFFFE, 1'b1, 8'd0}
  };
  localparam logic [23:0] RST_WORD = 24'h3C960F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] inData = '0;
  logic        inLast = 1'b0;
  logic        ledOut;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ledPulseEncoder i_ledPulseEncoder (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .inReady(inReady),
    .inData (inData),
    .inLast (inLast),
    .ledOut (ledOut),
    .busy   (busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // line monitor: pulse widths and bit decoding
  bit          monOff = 1'b0;
  logic        prevLevel = 1'b0;
  int          runLen = 0;
  int          bitsIn = 0;
  bit          haveBit = 1'b0;
  bit          prevBit = 1'b0;
  logic [23:0] acc = '0;
  int          lastLowRun = 0;
  logic [23:0] recv [16];
  int          recvCnt = 0;

  always @(negedge clk) begin
    if (rst || monOff) begin
      prevLevel = 1'b0;
      runLen    = 0;
      bitsIn    = 0;
      haveBit   = 1'b0;
    end else if (ledOut === prevLevel) begin
      runLen++;
    end else begin
      if (prevLevel) begin
        // R3: high width decides the bit
        bit b;
        check(runLen == H1 || runLen == H1 + D2, "R3", "high width",
              runLen, H1);
        b = (runLen == H1 + D2);
        acc = {acc[22:0], b};
        prevBit = b;
        haveBit = 1'b1;
        bitsIn++;
        if (bitsIn == 24) begin
          if (recvCnt < 16) recv[recvCnt] = acc;
          recvCnt++;
          bitsIn = 0;
        end
      end else begin
        lastLowRun = runLen;
        if (haveBit)
          check(runLen >= (prevBit ? L3 : D2 + L3), "R3", "low width",
                runLen, prevBit ? L3 : D2 + L3);
      end
      prevLevel = ledOut;
      runLen = 1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      finishRun();
    end
  end

  task automatic sendWord(input logic [23:0] d, input logic l);
    inData  = d;
    inLast  = l;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    // R2: line high in the cycle after acceptance
    check(ledOut == 1'b1, "R2", "line after accept", ledOut, 1);
  endtask

  task automatic frameTail(input bit endBit);
    int cnt = 0;
    bit rdyBad = 1'b0;
    int exp;
    exp = (endBit ? L3 : D2 + L3) + LT;
    @(negedge clk);
    while (busy) begin
      if (ledOut) cnt = 0;
      else begin
        cnt++;
        if (inReady) rdyBad = 1'b1;
      end
      @(negedge clk);
    end
    // R7: low tail length and no ready during it
    check(cnt == exp, "R7", "tail low cycles", cnt, exp);
    check(!rdyBad, "R7", "ready during tail", rdyBad, 0);
    // R8: idle state
    check(ledOut == 1'b0 && inReady == 1'b1, "R8", "idle outputs",
          {ledOut, inReady}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(ledOut == 1'b0 && busy == 1'b0 && inReady == 1'b1, "R1",
          "state after reset", {ledOut, busy, inReady}, 3'b001);
    @(negedge clk);
    check(ledOut == 1'b0 && busy == 1'b0, "R8", "idle before traffic",
          {ledOut, busy}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].delay != 0) begin
        bit idleBad = 1'b0;
        while (!inReady) @(negedge clk);
        for (int k = 0; k < int'(VECS[i].delay); k++) begin
          @(negedge clk);
          if (ledOut || !busy || !inReady) idleBad = 1'b1;
        end
        // R6: late word keeps line low and block busy
        check(!idleBad, "R6", "waiting line state", idleBad, 0);
      end
      sendWord(VECS[i].data, VECS[i].last);
      if (i > 0 && !VECS[i-1].last && VECS[i].delay == 0) begin
        int expGap;
        expGap = VECS[i-1].data[0] ? L3 : D2 + L3;
        @(negedge clk);
        // R5: back-to-back words add no extra low time
        check(lastLowRun == expGap, "R5", "gap between words",
              lastLowRun, expGap);
      end
      if (VECS[i].last) frameTail(VECS[i].data[0]);
    end

    // R1: reset in the middle of a word
    monOff = 1'b1;
    @(negedge clk);
    sendWord(24'hFFFFFF, 1'b0);
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(ledOut == 1'b0 && busy == 1'b0 && inReady == 1'b1, "R1",
          "reset mid-word", {ledOut, busy, inReady}, 3'b001);
    rst = 1'b0;
    begin
      bit stray = 1'b0;
      repeat (100) begin
        @(negedge clk);
        if (ledOut || busy) stray = 1'b1;
      end
      check(!stray, "R1", "partial word discarded", stray, 0);
    end
    monOff = 1'b0;
    @(negedge clk);
    sendWord(RST_WORD, 1'b1);
    frameTail(RST_WORD[0]);

    // R4: decoded words in order, MSB of green first
    check(recvCnt == NV + 1, "R4", "word count", recvCnt, NV + 1);
    for (int i = 0; i < NV; i++)
      check(recv[i] == VECS[i].data, "R4", "decoded word", recv[i],
            VECS[i].data);
    check(recv[NV] == RST_WORD, "R4", "word after reset", recv[NV], RST_WORD);

    finishRun();
  end

endmodule